// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Cache Controller

This block is a small direct-mapped cache that sits between a processor's 32-bit load/store port and a slower backing memory. Its 1 KB of storage is organised as 32 lines of 32 bytes. Each line holds one tag. Validity is kept separately for each 8-byte quarter of the line, so every line has four valid flags. A read that hits returns its word one cycle after acceptance. A read miss fetches only the 8-byte piece that holds the requested word, as a single 64-bit beat, and returns the word when that beat arrives.

Every store is written through to memory. A store that hits also updates the enabled bytes in the cache. A store that misses follows a policy input. With allocation on, the block fetches the piece first, merges the store bytes into it and then keeps it. With allocation off, the cache is left untouched and only the memory write happens.

When a fill brings a different tag into a line, the valid flags of that line's other three pieces are cleared. Stale bytes from the previous owner can then never hit. The processor holds its request until the one-cycle response pulse, and `busy` marks the span during which a new request is not taken.

Top module: `sbcache_ctrl`

## Requirements
- R1: After reset every piece is invalid, `busy` and `rsp_valid` are 0, and the first read of any address issues a memory fetch.
- R2: A read whose tag (address bits 31..10) matches the line selected by bits 9..5, and whose piece (bits 4..3) is valid, returns the stored word with `rsp_valid` exactly one clock after acceptance and issues no memory read.
- R3: A read miss issues exactly one single-cycle `mem_rd_req` with `mem_rd_addr` equal to the request address with bits 2..0 cleared. When the beat arrives it returns the word picked by address bit 2 (bit 2 = 0 selects beat bits 31..0).
- R4: A fill validates only the addressed piece. Other pieces of the same line that hold the same tag keep their valid flags, and pieces not yet fetched still miss.
- R5: A fill that installs a new tag in a line clears the valid flags of the line's other pieces, so they miss afterwards.
- R6: Every store produces exactly one `mem_wr_valid` pulse carrying the request address, data and byte enables (bit i enables data bits 8i+7..8i), in the same cycle as its `rsp_valid`.
- R7: A store hit completes one clock after acceptance, without a memory read, and changes only the enabled bytes of the cached word.
- R8: A store miss with `wr_alloc`=1 fetches the piece, merges the store bytes into it and installs it, so later reads of that piece hit.
- R9: A store miss with `wr_alloc`=0 completes one clock after acceptance, with no memory read and no change to the cache.
- R10: Addresses that share bits 9..5 but differ in bits 31..10 evict each other. An access with the other tag misses.
- R11: `busy` is high from acceptance until the response. `req_valid` and the request fields are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| wr_alloc | input | 1 | Store-miss policy: 1 allocate, 0 no allocate |
| busy | output | 1 | Request in flight, processor stalled |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result |
| mem_rd_req | output | 1 | Piece fetch request pulse |
| mem_rd_addr | output | 32 | Piece-aligned fetch address |
| mem_rd_valid | input | 1 | Fetch beat valid |
| mem_rd_data | input | 64 | Fetch beat |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | 32 | Write-through address |
| mem_wr_data | output | 32 | Write-through data |
| mem_wr_be | output | 4 | Write-through byte enables |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 32 lines of 32 bytes and 8-byte pieces, so all 128 line/piece slots can be swept in full. It also steps through all fifteen nonzero store byte-enable patterns on one cached word. Against a bench-side model of tags and piece flags, it covers fetching the first piece of each line and then every sibling, a hit on the other word of each piece, and the tag-replacement clearing on an aliased index. The memory model answers after a fixed latency, so the distinction between one-cycle hits and fetches is checked for every access.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } sbc_state_e;
endpackage

// File: rtl/sbc_tag_store.sv
module sbc_tag_store #(
  parameter int LINES = 32,
  parameter int SUBS  = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [SUB_W-1:0] lk_sub,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [SUB_W-1:0] upd_sub,
  input  logic [TAG_W-1:0] upd_tag
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [SUBS-1:0]  vld_q [LINES];

  logic same_tag;
  assign same_tag = (tag_q[upd_idx] == upd_tag);
  assign lk_hit   = vld_q[lk_idx][lk_sub] && (tag_q[lk_idx] == lk_tag);

  always_ff @(posedge clk) begin
    if (upd_en) tag_q[upd_idx] <= upd_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
    end else if (upd_en) begin
      if (same_tag) vld_q[upd_idx] <= vld_q[upd_idx] | (SUBS'(1) << upd_sub);
      else          vld_q[upd_idx] <= SUBS'(1) << upd_sub;
    end
  end
endmodule

// File: rtl/sbc_data_ram.sv
module sbc_data_ram #(
  parameter int DEPTH = 128,
  parameter int BYTES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = BYTES * 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [BYTES-1:0] wbe,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BYTES; b++)
        if (wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbcache_ctrl.sv
module sbcache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 32,
  parameter int SUB_BYTES  = 8,
  parameter int LINES      = 32,
  localparam int WORD_W  = WORD_BYTES * 8,
  localparam int BEAT_W  = SUB_BYTES * 8,
  localparam int SUBS    = LINE_BYTES / SUB_BYTES,
  localparam int HALVES  = SUB_BYTES / WORD_BYTES,
  localparam int WOFS_W  = $clog2(WORD_BYTES),
  localparam int SOFS_W  = $clog2(SUB_BYTES),
  localparam int LOFS_W  = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(LINES),
  localparam int SUB_W   = $clog2(SUBS),
  localparam int HSEL_W  = SOFS_W - WOFS_W,
  localparam int TAG_W   = ADDR_W - LOFS_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  input  logic [WORD_BYTES-1:0] req_be,
  input  logic                  wr_alloc,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_rdata,
  output logic                  mem_rd_req,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [BEAT_W-1:0]     mem_rd_data,
  output logic                  mem_wr_valid,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  output logic [WORD_W-1:0]     mem_wr_data,
  output logic [WORD_BYTES-1:0] mem_wr_be
);
  import sbc_pkg::*;

  sbc_state_e state;

  logic                  rq_we;
  logic                  rq_alloc;
  logic [ADDR_W-1:0]     rq_addr;
  logic [WORD_W-1:0]     rq_wdata;
  logic [WORD_BYTES-1:0] rq_be;

  logic [TAG_W-1:0]  rq_tag;
  logic [IDX_W-1:0]  rq_idx;
  logic [SUB_W-1:0]  rq_sub;
  logic [HSEL_W-1:0] rq_half;

  assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
  assign rq_idx  = rq_addr[LOFS_W +: IDX_W];
  assign rq_sub  = rq_addr[SOFS_W +: SUB_W];
  assign rq_half = rq_addr[WOFS_W +: HSEL_W];

  logic accept;
  assign accept = (state == ST_IDLE) && req_valid;

  // tag/valid lookup
  logic hit;
  logic fill_now;
  assign fill_now = (state == ST_FILL) && mem_rd_valid;

  sbc_tag_store #(.LINES(LINES), .SUBS(SUBS), .TAG_W(TAG_W)) i_tags (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (rq_idx),
    .lk_sub (rq_sub),
    .lk_tag (rq_tag),
    .lk_hit (hit),
    .upd_en (fill_now),
    .upd_idx(rq_idx),
    .upd_sub(rq_sub),
    .upd_tag(rq_tag)
  );

  // store lane placement within a piece
  logic [SUB_BYTES-1:0] wide_be;
  logic [BEAT_W-1:0]    wide_wd;
  logic [BEAT_W-1:0]    merged;

  always_comb begin
    wide_be = '0;
    wide_be[rq_half*WORD_BYTES +: WORD_BYTES] = rq_be;
    wide_wd = {HALVES{rq_wdata}};
    for (int b = 0; b < SUB_BYTES; b++)
      merged[b*8 +: 8] = (rq_we && wide_be[b]) ? wide_wd[b*8 +: 8] : mem_rd_data[b*8 +: 8];
  end

  // data array
  logic                   ram_we;
  logic [SUB_BYTES-1:0]   ram_wbe;
  logic [BEAT_W-1:0]      ram_wdata;
  logic [BEAT_W-1:0]      ram_q;

  always_comb begin
    ram_we    = fill_now || ((state == ST_LOOK) && rq_we && hit);
    ram_wbe   = fill_now ? '1 : wide_be;
    ram_wdata = fill_now ? merged : wide_wd;
  end

  sbc_data_ram #(.DEPTH(LINES * SUBS), .BYTES(SUB_BYTES)) i_data (
    .clk  (clk),
    .we   (ram_we),
    .wbe  (ram_wbe),
    .waddr({rq_idx, rq_sub}),
    .wdata(ram_wdata),
    .re   (accept),
    .raddr({req_addr[LOFS_W +: IDX_W], req_addr[SOFS_W +: SUB_W]}),
    .rdata(ram_q)
  );

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      busy         <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_wr_be    <= '0;
      rq_we        <= 1'b0;
      rq_alloc     <= 1'b0;
      rq_addr      <= '0;
      rq_wdata     <= '0;
      rq_be        <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      mem_rd_req   <= 1'b0;
      mem_wr_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rq_we    <= req_we;
            rq_alloc <= wr_alloc;
            rq_addr  <= req_addr;
            rq_wdata <= req_wdata;
            rq_be    <= req_be;
            busy     <= 1'b1;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit || (rq_we && !rq_alloc)) begin
            rsp_valid <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
            if (rq_we) begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= rq_addr;
              mem_wr_data  <= rq_wdata;
              mem_wr_be    <= rq_be;
            end else begin
              rsp_rdata <= ram_q[rq_half*WORD_W +: WORD_W];
            end
          end else begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= {rq_addr[ADDR_W-1:SOFS_W], {SOFS_W{1'b0}}};
            state       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_valid) begin
            rsp_valid <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
            if (rq_we) begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= rq_addr;
              mem_wr_data  <= rq_wdata;
              mem_wr_be    <= rq_be;
            end else begin
              rsp_rdata <= mem_rd_data[rq_half*WORD_W +: WORD_W];
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic rsp_valid,
  input logic mem_rd_req,
  input logic mem_wr_valid
);
  // R1: outputs idle in the cycle after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !rsp_valid));

  // R3: a fetch is a single pulse and the request stays in flight
  assert_fetch_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> (!mem_rd_req && busy));

  // R3: fetches happen only while a request is in flight
  assert_fetch_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> busy);

  // R6: write-through pulse coincides with completion
  assert_write_with_rsp_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> rsp_valid);

  // R11: completion releases the stall
  assert_rsp_releases_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R11: no completion in the cycle a request is taken
  assert_no_rsp_on_accept_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !rsp_valid);
endmodule

bind sbcache_ctrl sbc_checker i_sbc_checker (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .rsp_valid   (rsp_valid),
  .mem_rd_req  (mem_rd_req),
  .mem_wr_valid(mem_wr_valid)
);

// File: tb/test_sbcache_ctrl.sv
module test_sbcache_ctrl;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_we, wr_alloc;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_data;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;

  always #5 clk = ~clk;

  sbcache_ctrl i_sbcache_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .wr_alloc(wr_alloc), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic ok, input string lab, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", lab, act, exp);
    end
  endtask

  // backing memory
  logic [31:0] bmem [logic [31:0]];
  function automatic logic [31:0] word(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (bmem.exists(w)) return bmem[w];
    return (w * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic [3:0]  last_wr_be;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] fill_addr;

  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rd_data  = {word(fill_addr + 32'd4), word(fill_addr)};
        mem_rd_valid = 1'b1;
        pend = 1'b0;
      end else cnt--;
    end
    if (!rst && mem_rd_req) begin
      rd_cnt++;
      last_rd_addr = mem_rd_addr;
      fill_addr = mem_rd_addr;
      pend = 1'b1;
      cnt = LAT - 1;
    end
    if (!rst && mem_wr_valid) begin
      logic [31:0] w;
      w = word(mem_wr_addr);
      for (int b = 0; b < 4; b++) if (mem_wr_be[b]) w[b*8 +: 8] = mem_wr_data[b*8 +: 8];
      bmem[{mem_wr_addr[31:2], 2'b00}] = w;
      wr_cnt++;
      last_wr_addr = mem_wr_addr;
      last_wr_data = mem_wr_data;
      last_wr_be   = mem_wr_be;
    end
  end

  // bench model of tags and piece flags
  logic [21:0] mtag [32];
  logic [3:0]  mval [32];

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                     input logic [3:0] be, input logic alloc, input logic noisy,
                     output logic missed);
    logic [4:0]  idx = a[9:5];
    logic [1:0]  sub = a[4:3];
    logic [21:0] tg  = a[31:10];
    logic        hit = mval[idx][sub] && (mtag[idx] == tg);
    logic [31:0] exp_rd = word(a);
    int          r0 = rd_cnt, w0 = wr_cnt, cyc = 0, exp_rds;
    string       lab;
    lab = !we ? (hit ? "R2" : "R3") : (hit ? "R7" : (alloc ? "R8" : "R9"));
    exp_rds = (!hit && (!we || alloc)) ? 1 : 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_be = be; wr_alloc = alloc;
    @(negedge clk);
    if (noisy) begin
      chk(busy == 1'b1, "R11 busy after accept", busy, 1);
      req_we = 1'b1; req_addr = a ^ 32'h0000_5560; req_wdata = 32'h1234_5678; req_be = 4'hF;
    end else req_valid = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rsp_valid && cyc < 60);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid, {lab, " response"}, rsp_valid, 1);
    if (!we) chk(rsp_rdata == exp_rd, {lab, " read data"}, rsp_rdata, exp_rd);
    chk(rd_cnt - r0 == exp_rds, {lab, " fetch count"}, rd_cnt - r0, exp_rds);
    if (exp_rds == 1)
      chk(last_rd_addr == {a[31:3], 3'b000}, "R3 fetch address", last_rd_addr, {a[31:3], 3'b000});
    chk(wr_cnt - w0 == (we ? 1 : 0), "R6 write-through count", wr_cnt - w0, we ? 1 : 0);
    if (we) begin
      chk(last_wr_addr == a && last_wr_data == wd && last_wr_be == be, "R6 write-through fields",
          {last_wr_addr, last_wr_data}, {a, wd});
    end
    if (hit || (we && !alloc)) chk(cyc == 1, {lab, " one-cycle completion"}, cyc, 1);
    if (exp_rds == 1) begin
      if (mtag[idx] != tg) mval[idx] = 4'b0000;
      mtag[idx] = tg;
      mval[idx][sub] = 1'b1;
    end
    missed = (rd_cnt - r0) > 0;
  endtask

  localparam logic [21:0] T1 = 22'h00ABC, T2 = 22'h03F00, T3 = 22'h00155;

  function automatic logic [31:0] ad(input logic [21:0] t, input int idx, input int sub, input int wsel);
    return {t, idx[4:0], sub[1:0], wsel[0], 2'b00};
  endfunction

  initial begin
    logic m;
    logic [31:0] old, mg;
    for (int i = 0; i < 32; i++) begin mtag[i] = '0; mval[i] = '0; end
    req_valid = 0; req_we = 0; req_addr = 0; req_wdata = 0; req_be = 0; wr_alloc = 0;
    mem_rd_valid = 0; mem_rd_data = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_rd_req, "R1 idle outputs after reset", {busy, rsp_valid, mem_rd_req}, 0);

    // sweep every line and piece under one tag
    for (int l = 0; l < 32; l++) begin
      for (int s = 0; s < 4; s++) begin
        acc(0, ad(T1, l, s, s & 1), 0, 0, 0, 0, m);
        chk(m, "R1 R4 unfetched piece misses", m, 1);
        acc(0, ad(T1, l, s, (s & 1) ^ 1), 0, 0, 0, 0, m);
        chk(!m, "R2 other word of filled piece hits", m, 0);
      end
      acc(0, ad(T1, l, 0, 0), 0, 0, 0, 0, m);
      chk(!m, "R4 earlier piece still valid", m, 0);
    end

    // tag replacement on line 3
    acc(0, ad(T2, 3, 0, 0), 0, 0, 0, 0, m);
    chk(m, "R10 aliased tag misses", m, 1);
    acc(0, ad(T2, 3, 1, 1), 0, 0, 0, 0, m);
    chk(m, "R5 sibling cleared by new tag", m, 1);
    acc(0, ad(T1, 3, 2, 0), 0, 0, 0, 0, m);
    chk(m, "R10 old tag evicted", m, 1);
    acc(0, ad(T2, 3, 1, 0), 0, 0, 0, 0, m);
    chk(m, "R5 cleared again after swap back", m, 1);

    // store hits with every byte-enable pattern
    for (int be = 1; be < 16; be++) begin
      logic [31:0] a = ad(T1, 5, 1, 1);
      logic [31:0] wd = 32'hDEAD_BEEF ^ (be * 32'h0101_0101);
      old = word(a);
      mg = old;
      for (int b = 0; b < 4; b++) if (be[b]) mg[b*8 +: 8] = wd[b*8 +: 8];
      acc(1, a, wd, be[3:0], 1, 0, m);
      chk(!m, "R7 store hit no fetch", m, 0);
      acc(0, a, 0, 0, 0, 0, m);
      chk(rsp_rdata == mg && !m, "R7 merged bytes read back", rsp_rdata, mg);
    end

    // store miss with allocation
    acc(1, ad(T3, 7, 2, 0), 32'hCAFE_F00D, 4'b0110, 1, 0, m);
    chk(m, "R8 allocating store fetches", m, 1);
    acc(0, ad(T3, 7, 2, 0), 0, 0, 0, 0, m);
    chk(!m, "R8 allocated word hits", m, 0);
    acc(0, ad(T3, 7, 2, 1), 0, 0, 0, 0, m);
    chk(!m, "R8 whole piece installed", m, 0);

    // store miss without allocation
    acc(1, ad(T3, 9, 0, 0), 32'h0BAD_F00D, 4'b1111, 0, 0, m);
    chk(!m, "R9 no fetch", m, 0);
    acc(0, ad(T3, 9, 0, 0), 0, 0, 0, 0, m);
    chk(m, "R9 cache left unchanged", m, 1);
    chk(rsp_rdata == 32'h0BAD_F00D, "R9 memory holds store", rsp_rdata, 32'h0BAD_F00D);

    // requests ignored while busy
    acc(0, ad(T3, 11, 1, 0), 0, 0, 0, 1, m);
    chk(m, "R11 miss under noise", m, 1);
    acc(0, ad(T3, 11, 1, 0) ^ 32'h0000_5560, 0, 0, 0, 0, m);
    chk(m, "R11 noisy address never taken", m, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule